// File: doc/BRIEF.md
# Register-Mapped Tick Timer

This block is a free-running tick timer that a processor core reaches through its special-purpose register port. Software sees two registers. The control register selects how the timer behaves, sets the compare period, enables the interrupt and holds a sticky pending flag. The count register holds the live count, which advances by one each clock while the timer runs.

When the low bits of the count equal the period, the pending flag is set. The timer then restarts from zero, stops, or keeps counting, according to its mode. The interrupt line to the core is high while the pending flag and the enable bit are both set. Counting starts and stops only when a control write changes the mode field. Software acknowledges an interrupt by writing the control register with a zero in the pending position. A one in that position leaves the flag as it was, so a write that only changes other fields cannot drop an unserviced tick.

Top module: `tt_tick_timer`

## Requirements
- R1: After reset, both registers read zero, the interrupt line is low and the count does not advance.
- R2: Control register layout, with the data width W (32 by default): bits W-1:W-2 hold the mode (00 off, 01 restart, 10 one-shot, 11 continuous), bit W-3 enables the interrupt, bit W-4 is the pending flag, and bits W-5:0 hold the period. A read returns the stored value, including the current pending flag.
- R3: A control write that changes the mode field to 00 stops counting, and one that changes it to any other value starts counting. A control write that leaves the mode field unchanged does not change whether the timer runs.
- R4: On a control write, a 1 in bit W-4 keeps the stored pending flag and a 0 clears it, which withdraws the interrupt.
- R5: While the timer runs, a clock edge at which the low W-4 bits of the count equal the period sets the pending flag. No match occurs while the timer is stopped, and the flag stays set until a control write clears it.
- R6: At a match edge, restart mode loads the count with zero. One-shot mode holds the count and stops the timer. Continuous mode keeps incrementing, with wraparound over the full W bits.
- R7: A count-register write loads the written value and takes precedence over the increment in that cycle. Later match checks compare the new value.
- R8: The interrupt output is high exactly when the pending flag and the enable bit are both 1.
- R9: The control register sits at address 0x5000 (group 10, entry 0, where address = group*2048 + entry) and the count register at 0x5001. Writes to any other address change nothing, and reads from any other address return zero.
- R10: A count-register read returns the live count, which rises by one at each clock edge while the timer runs and no match or write intervenes.
- R11: When a control write and a match fall on the same edge, the pending flag follows the write rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_wr | input | 1 | Write strobe for the register port |
| spr_addr | input | ADDR_W | Register address |
| spr_wdata | input | DATA_W | Write data |
| spr_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| tick_irq | output | 1 | Timer interrupt to the core |

## Verification
The bench builds the timer with an 8-bit data width. This leaves a 4-bit period field and an 8-bit count. With these sizes, every period value can be swept in all three counting modes, with the interrupt enable both on and off. A continuous run also crosses the 8-bit wraparound and the repeated matches that follow it, all within a few hundred cycles. Directed sequences place control writes on match edges, reload the count, and send accesses to neighbouring unmapped addresses. A cycle-level model in the bench, written from the requirements, predicts the count, the control readback and the interrupt after every edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

    // Timer operating modes held in the top two bits of the control register
    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_ONESHOT = 2'b10,
        TM_FREE    = 2'b11
    } tmode_e;

    // Register group index shift of the special-register address space
    localparam int unsigned TT_GROUP_SHIFT = 11;
    localparam int unsigned TT_GROUP       = 10;
    localparam int unsigned TT_IDX_CTRL    = 0;
    localparam int unsigned TT_IDX_COUNT   = 1;

    // Decoded access strobes
    typedef struct packed {
        logic wr_ctrl;
        logic wr_cnt;
        logic sel_ctrl;
        logic sel_cnt;
    } tt_sel_t;

    function automatic int unsigned tt_addr(input int unsigned group, input int unsigned idx);
        return (group << TT_GROUP_SHIFT) + idx;
    endfunction

endpackage

// File: rtl/tt_decode.sv
module tt_decode
    import tt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output tt_sel_t           sel
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(tt_addr(TT_GROUP, TT_IDX_CTRL));
    localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(tt_addr(TT_GROUP, TT_IDX_COUNT));

    always_comb begin
        sel.sel_ctrl = (addr == CTRL_A);
        sel.sel_cnt  = (addr == COUNT_A);
        sel.wr_ctrl  = wr && sel.sel_ctrl;
        sel.wr_cnt   = wr && sel.sel_cnt;
    end
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
    import tt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              run
);
    localparam int PEND_BIT = DATA_W - 4;
    localparam int PER_W    = DATA_W - 4;

    tmode_e cur_mode, new_mode;
    logic   changed, oneshot_stop;

    assign cur_mode     = tmode_e'(ctrl_q[DATA_W-1 -: 2]);
    assign new_mode     = tmode_e'(wdata[DATA_W-1 -: 2]);
    assign changed      = wr_ctrl && (new_mode != cur_mode);
    assign oneshot_stop = match && (cur_mode == TM_ONESHOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            run    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                // Write data one keeps the flag, zero clears it
                ctrl_q <= {wdata[DATA_W-1:PEND_BIT+1],
                           wdata[PEND_BIT] & ctrl_q[PEND_BIT],
                           wdata[PER_W-1:0]};
            end else if (match) begin
                ctrl_q[PEND_BIT] <= 1'b1;
            end

            if (changed)
                run <= (new_mode != TM_OFF);
            else if (oneshot_stop)
                run <= 1'b0;
        end
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  tmode_e              mode,
    input  logic [DATA_W-5:0]   period,
    input  logic                wr_cnt,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   cnt,
    output logic                match
);
    localparam int PER_W = DATA_W - 4;

    logic [DATA_W-1:0] inc;

    assign inc   = cnt + DATA_W'(1);
    assign match = run && (cnt[PER_W-1:0] == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wdata;
        end else if (run) begin
            unique case (mode)
                TM_RESTART: cnt <= match ? '0  : inc;
                TM_ONESHOT: cnt <= match ? cnt : inc;
                default:    cnt <= inc;
            endcase
        end
    end
endmodule

// File: rtl/tt_tick_timer.sv
module tt_tick_timer
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spr_wr,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    output logic              tick_irq
);
    localparam int PEND_BIT = DATA_W - 4;
    localparam int IE_BIT   = DATA_W - 3;
    localparam int PER_W    = DATA_W - 4;

    tt_sel_t           sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnt;
    logic              run;
    logic              match;

    tt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (spr_wr),
        .addr (spr_addr),
        .sel  (sel)
    );

    tt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (sel.wr_ctrl),
        .wdata   (spr_wdata),
        .match   (match),
        .ctrl_q  (ctrl_q),
        .run     (run)
    );

    tt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .mode   (tmode_e'(ctrl_q[DATA_W-1 -: 2])),
        .period (ctrl_q[PER_W-1:0]),
        .wr_cnt (sel.wr_cnt),
        .wdata  (spr_wdata),
        .cnt    (cnt),
        .match  (match)
    );

    always_comb begin
        if (sel.sel_ctrl)
            spr_rdata = ctrl_q;
        else if (sel.sel_cnt)
            spr_rdata = cnt;
        else
            spr_rdata = '0;
    end

    assign tick_irq = ctrl_q[PEND_BIT] & ctrl_q[IE_BIT];
endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_ctrl,
    input logic              wr_cnt,
    input logic [1:0]        wr_mode,
    input logic              wr_pend,
    input logic [1:0]        mode,
    input logic              pend,
    input logic              run,
    input logic              match,
    input logic [DATA_W-1:0] cnt,
    input logic              tick_irq
);
    // R10: live count advances by one when running without match or write
    a_r10_increment: assert property (@(posedge clk) disable iff (rst)
        (run && !match && !wr_cnt) |=> (cnt == $past(cnt) + DATA_W'(1)));

    // R3: a stopped timer keeps its count unless written
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt));

    // R3: changing the mode to off stops counting
    a_r3_off_stops: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_mode == 2'b00) |=> !run);

    // R6: restart mode reloads zero on a match
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (match && mode == 2'b01 && !wr_cnt) |=> (cnt == '0));

    // R6: one-shot mode stops on a match
    a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (match && mode == 2'b10 && !(wr_ctrl && wr_mode != 2'b10)) |=> !run);

    // R5: pending flag is sticky without a control write
    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend && !wr_ctrl) |=> pend);

    // R4: writing zero to the pending position withdraws the interrupt
    a_r4_clear_withdraws: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_pend) |=> !tick_irq);
endmodule

bind tt_tick_timer tt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (sel.wr_ctrl),
    .wr_cnt   (sel.wr_cnt),
    .wr_mode  (spr_wdata[DATA_W-1 -: 2]),
    .wr_pend  (spr_wdata[DATA_W-4]),
    .mode     (ctrl_q[DATA_W-1 -: 2]),
    .pend     (ctrl_q[DATA_W-4]),
    .run      (run),
    .match    (match),
    .cnt      (cnt),
    .tick_irq (tick_irq)
);

// File: tb/sim_tt_tick_timer.sv
module sim_tt_tick_timer;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int PW = DW - 4;
    localparam logic [AW-1:0] A_CTRL = 16'h5000;
    localparam logic [AW-1:0] A_CNT  = 16'h5001;

    logic          clk = 1'b0;
    logic          rst;
    logic          spr_wr;
    logic [AW-1:0] spr_addr;
    logic [DW-1:0] spr_wdata;
    logic [DW-1:0] spr_rdata;
    logic          tick_irq;

    int checks = 0;
    int fails  = 0;

    // Bench model state, built from the requirements
    logic [DW-1:0] m_ctrl;
    logic [DW-1:0] m_cnt;
    logic          m_run;

    always #4 clk = ~clk;

    tt_tick_timer #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .spr_wr    (spr_wr),
        .spr_addr  (spr_addr),
        .spr_wdata (spr_wdata),
        .spr_rdata (spr_rdata),
        .tick_irq  (tick_irq)
    );

    function automatic logic [DW-1:0] cword(input logic [1:0] md, input logic ie,
                                            input logic pd, input logic [PW-1:0] per);
        return {md, ie, pd, per};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Observe both registers and the interrupt line (called near negedge)
    task automatic observe(input string req);
        logic [AW-1:0] keep;
        keep = spr_addr;
        spr_addr = A_CNT;
        #1 chk(req, "count(R10)", spr_rdata, m_cnt);
        spr_addr = A_CTRL;
        #1 chk(req, "ctrl(R2)", spr_rdata, m_ctrl);
        chk(req, "irq(R8)", DW'(tick_irq), DW'(m_ctrl[DW-3] & m_ctrl[DW-4]));
        spr_addr = keep;
    endtask

    // One clock with an optional write; the model advances alongside
    task automatic cycle(input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string req);
        logic [1:0]    md;
        logic          mt;
        logic [DW-1:0] n_ctrl, n_cnt;
        logic          n_run;
        md = m_ctrl[DW-1 -: 2];
        mt = m_run && (m_cnt[PW-1:0] == m_ctrl[PW-1:0]);
        n_ctrl = m_ctrl;
        n_cnt  = m_cnt;
        n_run  = m_run;
        // R7 count write wins; R6 post-match behaviour
        if (we && a == A_CNT) n_cnt = d;
        else if (m_run) begin
            if (mt && md == 2'b01) n_cnt = '0;
            else if (mt && md == 2'b10) n_cnt = m_cnt;
            else n_cnt = m_cnt + 1'b1;
        end
        // R4, R11 control write; R5 match sets pending
        if (we && a == A_CTRL) begin
            n_ctrl = d;
            n_ctrl[DW-4] = d[DW-4] & m_ctrl[DW-4];
        end else if (mt) n_ctrl[DW-4] = 1'b1;
        // R3 run state changes only on a mode change; R6 one-shot stop
        if (we && a == A_CTRL && d[DW-1 -: 2] != md) n_run = (d[DW-1 -: 2] != 2'b00);
        else if (mt && md == 2'b10) n_run = 1'b0;

        spr_wr = we; spr_addr = a; spr_wdata = d;
        @(posedge clk);
        @(negedge clk);
        spr_wr = 1'b0;
        m_ctrl = n_ctrl; m_cnt = n_cnt; m_run = n_run;
        observe(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cycle(1'b0, A_CTRL, '0, req);
    endtask

    task automatic do_reset();
        rst = 1'b1; spr_wr = 1'b0; spr_addr = A_CTRL; spr_wdata = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ctrl = '0; m_cnt = '0; m_run = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, and no counting afterwards
        do_reset();
        observe("R1");
        idle(3, "R1");

        // R5 R6 R8: sweep every mode, period and enable
        for (int md = 1; md < 4; md++) begin
            for (int per = 0; per < (1 << PW); per++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    do_reset();
                    cycle(1'b1, A_CTRL, cword(2'(md), 1'(ie), 1'b0, PW'(per)), "R3");
                    idle(per + 6, "R6");
                end
            end
        end

        // R6: continuous wraparound across the full count width
        do_reset();
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b0, 4'd5), "R6");
        idle(300, "R6");

        // R4: pending write rules
        do_reset();
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b0, 4'd3), "R4");
        idle(5, "R4");
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b1, 4'd9), "R4");
        idle(1, "R4");
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b0, 4'd9), "R4");
        idle(2, "R4");

        // R11: control write on the match edge
        do_reset();
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b0, 4'd3), "R11");
        idle(3, "R11");
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b0, 4'd3), "R11");
        idle(2, "R11");
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b1, 1'b1, 4'd3), "R11");

        // R3: change to off stops; same-mode write keeps run state
        do_reset();
        cycle(1'b1, A_CTRL, cword(2'b01, 1'b0, 1'b0, 4'd12), "R3");
        idle(4, "R3");
        cycle(1'b1, A_CTRL, cword(2'b00, 1'b0, 1'b0, 4'd12), "R3");
        idle(4, "R3");
        cycle(1'b1, A_CTRL, cword(2'b10, 1'b1, 1'b0, 4'd2), "R3");
        idle(6, "R3");
        cycle(1'b1, A_CTRL, cword(2'b10, 1'b1, 1'b1, 4'd7), "R3");
        idle(4, "R3");

        // R7: count reload while running and while stopped
        do_reset();
        cycle(1'b1, A_CTRL, cword(2'b01, 1'b1, 1'b0, 4'd9), "R7");
        idle(2, "R7");
        cycle(1'b1, A_CNT, 8'd9, "R7");
        idle(3, "R7");
        cycle(1'b1, A_CNT, 8'hF7, "R7");
        idle(20, "R7");
        cycle(1'b1, A_CTRL, cword(2'b00, 1'b1, 1'b1, 4'd9), "R7");
        cycle(1'b1, A_CNT, 8'h42, "R7");
        idle(3, "R7");

        // R9: unmapped addresses are ignored and read zero
        do_reset();
        cycle(1'b1, 16'h5002, 8'hFF, "R9");
        cycle(1'b1, 16'h4800, 8'hFF, "R9");
        cycle(1'b1, 16'h0000, 8'hFF, "R9");
        cycle(1'b1, 16'hD000, 8'hFF, "R9");
        spr_addr = 16'h5002;
        #1 chk("R9", "unmapped read", spr_rdata, '0);
        cycle(1'b1, A_CTRL, cword(2'b11, 1'b0, 1'b0, 4'd1), "R9");
        idle(2, "R9");
        spr_addr = 16'h1001;
        #1 chk("R9", "unmapped read while running", spr_rdata, '0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule